// File: doc/BRIEF.md
# Multi-Context Configuration Plane Controller

This block governs a reconfigurable fabric that has four configuration memory planes and a single logic plane. At any moment at most one plane drives the logic. Callers ask for a context group by its ID over a valid/ready request channel. If the group already sits in a valid plane, the request is a hit: the controller takes it at once and moves the active selection to that plane in one clock edge.

If the group is not in any valid plane, the request is a miss. The controller picks a victim plane and starts an external loader on it. The victim is the least recently used plane, and the active plane is never chosen. The load runs in the background while the active plane keeps executing. When the loader reports completion, the controller marks the plane valid and makes it active.

Two counters record the accepted hits and the full-context loads. The contents of the bitstreams and the way operations are grouped into contexts are outside this block.

Top module: `ctx_plane_ctrl`

## Requirements
- R1: After reset no plane is valid, `active_valid_o` is 0, `active_plane_o` is 0, both counters are 0, `load_start_o` is 0 and `req_ready_o` is 1.
- R2: A hit is a request whose group ID matches a valid plane. It is accepted in the cycle it is presented, even while a load is pending. At that clock edge `active_plane_o` becomes the matching plane, `active_valid_o` becomes 1 and `hit_count_o` increments by one.
- R3: A miss accepted while idle increments `load_count_o` by one at the accepting edge. In the next cycle `load_start_o` is high for exactly one cycle, with `load_plane_o` naming the victim and `load_gid_o` carrying the requested ID. Both stay stable until completion. The victim plane stops matching from the accepting edge on.
- R4: Every plane holds a distinct age rank from 0 (newest) to 3 (oldest). After reset plane i has rank i. An accepted hit, and the victim of an accepted miss, both take rank 0, and every plane that was younger than it ages by one. The victim is the oldest plane that is not the valid active plane, so the first miss after reset loads plane 3.
- R5: The plane being loaded is never the valid active plane at any point during a load.
- R6: While a load is pending (the start cycle and the wait for completion), a request that misses sees `req_ready_o` low and is not accepted.
- R7: When `load_done_i` is high while the controller waits for completion, the loaded plane becomes valid with the loaded ID, it becomes the active plane at that edge, and the controller returns to idle. In that cycle `req_ready_o` is low.
- R8: `load_done_i` has no effect when no load is waiting for completion: the active plane, the valid state and the counters stay unchanged apart from what an accepted request does.
- R9: A group ID matches at most one valid plane at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request present |
| req_gid_i | input | GID_W | Requested context group ID |
| req_ready_o | output | 1 | Request accepted when high together with valid |
| load_start_o | output | 1 | One-cycle pulse that starts a plane load |
| load_plane_o | output | IDX_W | Plane being loaded |
| load_gid_o | output | GID_W | Group ID being loaded |
| load_done_i | input | 1 | Loader completion strobe |
| active_plane_o | output | IDX_W | Plane driving the logic |
| active_valid_o | output | 1 | An active plane has been selected |
| hit_count_o | output | CNT_W | Accepted hits |
| load_count_o | output | CNT_W | Full-context loads issued |

## Verification
The bench builds the controller with its default four planes, a 6-bit group ID and 16-bit counters. Random requests are drawn from only six group IDs. With four planes and six IDs, evictions, repeated hits, hits during a pending load and misses that stall during a load all occur often. The loader answers after random delays and sometimes raises spurious completion strobes while idle. Together these exercise the exclusion of the active plane from victim choice and the interaction between completion and new requests.

// File: rtl/ctx_plane_pkg.sv
package ctx_plane_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_WAIT  = 2'd2
  } ld_state_e;
endpackage

// File: rtl/ctx_tag_array.sv
module ctx_tag_array #(
  parameter int NUM_CTX = 4,
  parameter int GID_W   = 6,
  localparam int IDX_W  = $clog2(NUM_CTX)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [GID_W-1:0] lookup_gid_i,
  input  logic             inval_en_i,
  input  logic [IDX_W-1:0] inval_idx_i,
  input  logic             fill_en_i,
  input  logic [IDX_W-1:0] fill_idx_i,
  input  logic [GID_W-1:0] fill_gid_i,
  output logic             hit_o,
  output logic [IDX_W-1:0] hit_idx_o
);
  logic [NUM_CTX-1:0] valid_q;
  logic [GID_W-1:0]   gid_q [NUM_CTX];
  logic [NUM_CTX-1:0] hit_vec;

  for (genvar g = 0; g < NUM_CTX; g++) begin : g_plane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[g] <= 1'b0;
        gid_q[g]   <= '0;
      end else if (fill_en_i && fill_idx_i == IDX_W'(g)) begin
        valid_q[g] <= 1'b1;
        gid_q[g]   <= fill_gid_i;
      end else if (inval_en_i && inval_idx_i == IDX_W'(g)) begin
        valid_q[g] <= 1'b0;
      end
    end
    assign hit_vec[g] = valid_q[g] && (gid_q[g] == lookup_gid_i);
  end

  always_comb begin
    hit_idx_o = '0;
    for (int i = 0; i < NUM_CTX; i++) begin
      if (hit_vec[i]) hit_idx_o = IDX_W'(i);
    end
  end
  assign hit_o = |hit_vec;

  // a group ID may live in one plane only
  p_unique_match_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec));
endmodule

// File: rtl/ctx_lru_rank.sv
module ctx_lru_rank #(
  parameter int NUM_CTX = 4,
  localparam int IDX_W  = $clog2(NUM_CTX)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             touch_en_i,
  input  logic [IDX_W-1:0] touch_idx_i,
  input  logic             excl_en_i,
  input  logic [IDX_W-1:0] excl_idx_i,
  output logic [IDX_W-1:0] victim_idx_o
);
  logic [IDX_W-1:0]   age_q [NUM_CTX];
  logic [NUM_CTX-1:0] rank_match [NUM_CTX];

  for (genvar g = 0; g < NUM_CTX; g++) begin : g_age
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        age_q[g] <= IDX_W'(g);
      end else if (touch_en_i) begin
        if (touch_idx_i == IDX_W'(g))            age_q[g] <= '0;
        else if (age_q[g] < age_q[touch_idx_i])  age_q[g] <= age_q[g] + 1'b1;
      end
    end
  end

  // oldest plane outside the exclusion
  always_comb begin
    logic [IDX_W-1:0] best_age;
    best_age     = '0;
    victim_idx_o = '0;
    for (int i = 0; i < NUM_CTX; i++) begin
      if (!(excl_en_i && excl_idx_i == IDX_W'(i)) && age_q[i] >= best_age) begin
        best_age     = age_q[i];
        victim_idx_o = IDX_W'(i);
      end
    end
  end

  always_comb begin
    for (int r = 0; r < NUM_CTX; r++) begin
      for (int i = 0; i < NUM_CTX; i++) begin
        rank_match[r][i] = (age_q[i] == IDX_W'(r));
      end
    end
  end

  for (genvar r = 0; r < NUM_CTX; r++) begin : g_rank_chk
    p_rank_perm_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot(rank_match[r]));
  end

  p_victim_not_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    excl_en_i |-> victim_idx_o != excl_idx_i);
endmodule

// File: rtl/ctx_plane_ctrl.sv
module ctx_plane_ctrl
  import ctx_plane_pkg::*;
#(
  parameter int NUM_CTX = 4,
  parameter int GID_W   = 6,
  parameter int CNT_W   = 16,
  localparam int IDX_W  = $clog2(NUM_CTX)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [GID_W-1:0] req_gid_i,
  output logic             req_ready_o,
  output logic             load_start_o,
  output logic [IDX_W-1:0] load_plane_o,
  output logic [GID_W-1:0] load_gid_o,
  input  logic             load_done_i,
  output logic [IDX_W-1:0] active_plane_o,
  output logic             active_valid_o,
  output logic [CNT_W-1:0] hit_count_o,
  output logic [CNT_W-1:0] load_count_o
);
  ld_state_e        state_q;
  logic [IDX_W-1:0] active_q, ld_idx_q, victim_idx, hit_idx;
  logic             active_valid_q, hit;
  logic [GID_W-1:0] ld_gid_q;
  logic [CNT_W-1:0] hit_cnt_q, ld_cnt_q;
  logic             done_fire, fire, hit_fire, miss_fire;

  ctx_tag_array #(.NUM_CTX(NUM_CTX), .GID_W(GID_W)) u_tags (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .lookup_gid_i (req_gid_i),
    .inval_en_i   (miss_fire),
    .inval_idx_i  (victim_idx),
    .fill_en_i    (done_fire),
    .fill_idx_i   (ld_idx_q),
    .fill_gid_i   (ld_gid_q),
    .hit_o        (hit),
    .hit_idx_o    (hit_idx)
  );

  ctx_lru_rank #(.NUM_CTX(NUM_CTX)) u_lru (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .touch_en_i   (fire),
    .touch_idx_i  (hit ? hit_idx : victim_idx),
    .excl_en_i    (active_valid_q),
    .excl_idx_i   (active_q),
    .victim_idx_o (victim_idx)
  );

  assign done_fire   = (state_q == ST_WAIT) && load_done_i;
  // pending load: hits only, and none in the completion cycle
  assign req_ready_o = (state_q == ST_IDLE) || (hit && !done_fire);
  assign fire        = req_valid_i && req_ready_o;
  assign hit_fire    = fire && hit;
  assign miss_fire   = fire && !hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q        <= ST_IDLE;
      active_q       <= '0;
      active_valid_q <= 1'b0;
      ld_idx_q       <= '0;
      ld_gid_q       <= '0;
      hit_cnt_q      <= '0;
      ld_cnt_q       <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE:  if (miss_fire) state_q <= ST_START;
        ST_START: state_q <= ST_WAIT;
        ST_WAIT:  if (load_done_i) state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
      if (miss_fire) begin
        ld_idx_q <= victim_idx;
        ld_gid_q <= req_gid_i;
        ld_cnt_q <= ld_cnt_q + 1'b1;
      end
      if (hit_fire) begin
        active_q       <= hit_idx;
        active_valid_q <= 1'b1;
        hit_cnt_q      <= hit_cnt_q + 1'b1;
      end else if (done_fire) begin
        active_q       <= ld_idx_q;
        active_valid_q <= 1'b1;
      end
    end
  end

  assign load_start_o   = (state_q == ST_START);
  assign load_plane_o   = ld_idx_q;
  assign load_gid_o     = ld_gid_q;
  assign active_plane_o = active_q;
  assign active_valid_o = active_valid_q;
  assign hit_count_o    = hit_cnt_q;
  assign load_count_o   = ld_cnt_q;

  p_no_evict_active_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE && active_valid_o) |-> active_plane_o != load_plane_o);

  p_start_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_start_o |=> !load_start_o);

  p_load_cnt_start_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(load_count_o) |-> load_start_o);

  p_done_switch_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && load_done_i) |=>
      (active_valid_o && active_plane_o == $past(load_plane_o) && state_q == ST_IDLE));

  p_miss_stall_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE && req_valid_i && !hit) |=> $stable(load_count_o));

  p_stray_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_WAIT && load_done_i && !hit_fire) |=>
      ($stable(active_plane_o) && $stable(active_valid_o)));
endmodule

// File: tb/ctx_plane_ctrl_tb_top.sv
`timescale 1ns/1ps
module ctx_plane_ctrl_tb_top;
  localparam int NUM_CTX = 4;
  localparam int GID_W   = 6;
  localparam int CNT_W   = 16;
  localparam int IDX_W   = 2;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             req_valid_i = 1'b0;
  logic [GID_W-1:0] req_gid_i = '0;
  logic             load_done_i = 1'b0;
  logic             req_ready_o, load_start_o, active_valid_o;
  logic [IDX_W-1:0] load_plane_o, active_plane_o;
  logic [GID_W-1:0] load_gid_o;
  logic [CNT_W-1:0] hit_count_o, load_count_o;

  always #2.5 clk_i = ~clk_i;

  ctx_plane_ctrl #(.NUM_CTX(NUM_CTX), .GID_W(GID_W), .CNT_W(CNT_W)) dut_i (
    .clk_i, .rst_ni, .req_valid_i, .req_gid_i, .req_ready_o,
    .load_start_o, .load_plane_o, .load_gid_o, .load_done_i,
    .active_plane_o, .active_valid_o, .hit_count_o, .load_count_o
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // reference state
  bit m_valid [NUM_CTX];
  int m_gid   [NUM_CTX];
  int m_age   [NUM_CTX];
  int m_act, m_state, m_ldi, m_ldg, m_hits, m_loads;
  bit m_act_v;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NUM_CTX; i++) begin
      m_valid[i] = 0; m_gid[i] = 0; m_age[i] = i;
    end
    m_act = 0; m_act_v = 0; m_state = 0; m_ldi = 0; m_ldg = 0; m_hits = 0; m_loads = 0;
  endtask

  function automatic int m_hit_idx(input int gid);
    for (int i = 0; i < NUM_CTX; i++) if (m_valid[i] && m_gid[i] == gid) return i;
    return -1;
  endfunction

  function automatic int m_victim();
    int best = -1, v = 0;
    for (int i = 0; i < NUM_CTX; i++)
      if (!(m_act_v && i == m_act) && m_age[i] > best) begin best = m_age[i]; v = i; end
    return v;
  endfunction

  task automatic touch(input int p);
    int pa = m_age[p];
    for (int i = 0; i < NUM_CTX; i++) begin
      if (i == p) m_age[i] = 0;
      else if (m_age[i] < pa) m_age[i]++;
    end
  endtask

  task automatic check_outputs();
    check(active_plane_o == IDX_W'(m_act), "R2/R7 active plane", int'(active_plane_o), m_act);
    check(active_valid_o == m_act_v, "R2/R7 active valid", int'(active_valid_o), int'(m_act_v));
    check(load_start_o == (m_state == 1), "R3 start pulse", int'(load_start_o), int'(m_state == 1));
    if (m_state != 0) begin
      check(load_plane_o == IDX_W'(m_ldi), "R4 load plane", int'(load_plane_o), m_ldi);
      check(load_gid_o == GID_W'(m_ldg), "R3 load gid", int'(load_gid_o), m_ldg);
      check(!(m_act_v && active_plane_o == load_plane_o), "R5 active not loaded",
            int'(active_plane_o), m_ldi);
    end
    check(int'(hit_count_o) == m_hits, "R2 hit count", int'(hit_count_o), m_hits);
    check(int'(load_count_o) == m_loads, "R3 load count", int'(load_count_o), m_loads);
  endtask

  task automatic step(input bit v, input int gid, input bit done);
    int hi, prev;
    bit exp_rdy, fire;
    @(negedge clk_i);
    req_valid_i = v; req_gid_i = GID_W'(gid); load_done_i = done;
    #1;
    hi = m_hit_idx(gid);
    exp_rdy = (m_state == 0) || (hi >= 0 && !(m_state == 2 && done));
    check(req_ready_o == exp_rdy, (m_state == 2 && done) ? "R7 ready in done cycle" :
          (m_state != 0 ? "R6 ready while loading" : "R2 ready idle"),
          int'(req_ready_o), int'(exp_rdy));
    fire = v && exp_rdy;
    @(posedge clk_i);
    prev = m_state;
    if (fire) begin
      if (hi >= 0) begin
        m_act = hi; m_act_v = 1; m_hits++; touch(hi);
      end else begin
        int vi = m_victim();
        m_valid[vi] = 0; m_ldi = vi; m_ldg = gid; m_loads++; touch(vi); m_state = 1;
      end
    end
    if (prev == 1) m_state = 2;
    else if (prev == 2 && done) begin
      m_valid[m_ldi] = 1; m_gid[m_ldi] = m_ldg; m_act = m_ldi; m_act_v = 1; m_state = 0;
    end
    #1;
    check_outputs();
  endtask

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(posedge clk_i);
    #1;
    // R1 reset state
    check(req_ready_o == 1'b1, "R1 ready", int'(req_ready_o), 1);
    check(active_valid_o == 1'b0, "R1 active valid", int'(active_valid_o), 0);
    check(load_start_o == 1'b0, "R1 start", int'(load_start_o), 0);
    check(hit_count_o == '0 && load_count_o == '0, "R1 counters", int'(load_count_o), 0);
    @(negedge clk_i); rst_ni = 1'b1;

    // R8 stray done while idle
    step(0, 0, 1);
    check(active_valid_o == 1'b0, "R8 stray done", int'(active_valid_o), 0);
    // R4 first miss goes to plane 3
    step(1, 5, 0);
    check(load_plane_o == 2'd3 && load_start_o, "R4 first victim", int'(load_plane_o), 3);
    step(1, 5, 0);               // R6 same ID still missing: stalled
    step(0, 0, 0);
    step(0, 0, 1);               // R7 completion
    check(active_plane_o == 2'd3 && active_valid_o, "R7 switch on done", int'(active_plane_o), 3);
    step(1, 9, 0);               // R4 active plane 3 excluded -> plane 2
    check(load_plane_o == 2'd2, "R4 second victim", int'(load_plane_o), 2);
    step(1, 5, 0);               // R2 hit during load
    check(active_plane_o == 2'd3, "R2 hit while loading", int'(active_plane_o), 3);
    step(1, 9, 1);               // R6 still a miss, done in same cycle
    check(active_plane_o == 2'd2, "R7 switch after wait", int'(active_plane_o), 2);
    step(1, 5, 0);               // R2 plain hit
    check(int'(hit_count_o) == 2, "R2 hit count", int'(hit_count_o), 2);

    // random phase
    for (int c = 0; c < 4000; c++) begin
      bit v = ($urandom_range(0, 9) < 7);
      int g = $urandom_range(0, 5);
      bit d = (m_state == 2) ? ($urandom_range(0, 2) == 0) : ($urandom_range(0, 9) == 0);
      step(v, g, d);
    end
    step(0, 0, 0);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(5ns * 100000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule